// File: doc/BRIEF.md
# Follower Prefetch Waiting Table

This block sits in the private cache controller of one core and screens prefetches that carry a sharing-group tag. A small role map, written during group setup and again whenever the shared cache reassigns the group's lead core, says for each group whether this core leads or follows. A lead core's prefetch leaves at once on the lead channel, where the shared cache treats it as the trigger for pushing the line to every member of the group. A follower's prefetch is not sent. It is parked in a table of waiting lines instead, each with its own age counter.

A parked line is retired when its data comes back, whether as the group push or as a reply to a private request. When a line has waited longer than the programmable threshold, the block gives up on the push. It sends a private (unicast) request for that line, flagged as a timeout so that the shared cache can count slow leaders. Demand accesses to a parked line are held back and woken when the line arrives. Every incoming line is forwarded as a fill, even one that nobody is waiting for. When the table has no free slot, a follower prefetch goes out as a plain unicast request.

Top module: `fpw_table`

## Requirements
- R1: After reset every output valid is low, every group is a follower group and the table holds no line.
- R2: A prefetch whose group is marked leader appears on `lead_valid`/`lead_addr`/`lead_gid` one cycle later and parks nothing, so a later demand to that line passes.
- R3: A follower prefetch to a line not yet waiting, with a free slot, produces no output and parks the line, so that a later demand to it is held.
- R4: Every cycle with `dat_valid` high gives `fill_valid` with `fill_addr` equal to `dat_addr` one cycle later, and frees the matching waiting entry, so that a later demand to that line passes.
- R5: A demand to a waiting line produces no pass output. It leaves on `wake_valid`/`wake_addr` in the same cycle as the fill of that line. A demand to any other line leaves on `pass_valid`/`pass_addr` one cycle later, and so does a demand presented in the same cycle as the data for its line.
- R6: If a follower prefetch is sampled at edge k and no data for its line arrives, then at edge k+`thresh`+1 the block raises `uni_valid` with `uni_timeout`=1, the line address and the group. This happens once only, and the entry keeps holding demands until data arrives.
- R7: With all 64 (`ENTRIES`) slots in use, a follower prefetch to a line not already waiting appears one cycle later on `uni_valid` with `uni_timeout`=0.
- R8: Data whose line matches no entry is still filled and frees no entry; other waiting lines keep holding their demands.
- R9: A follower prefetch to a line that is already waiting merges into that entry: no output and no new slot.
- R10: Data for a line that arrives at the very edge where that line would time out retires the entry; no unicast request and no timeout flag are raised.
- R11: A role map write (`map_wr`, `map_gid`, `map_leader`=1 for leader, 0 for follower) decides the role used for every prefetch sampled after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | TMO_W (16) | Wait limit in cycles before the unicast fallback |
| map_wr | input | 1 | Role map write strobe |
| map_gid | input | GID_W (4) | Group written |
| map_leader | input | 1 | 1 = leader, 0 = follower |
| pf_valid | input | 1 | Group-tagged prefetch present |
| pf_gid | input | GID_W (4) | Prefetch group |
| pf_addr | input | ADDR_W (26) | Prefetch line address |
| dmd_valid | input | 1 | Demand access present |
| dmd_addr | input | ADDR_W (26) | Demand line address |
| dat_valid | input | 1 | Line data arriving (push or unicast reply) |
| dat_addr | input | ADDR_W (26) | Arriving line address |
| lead_valid | output | 1 | Leader prefetch sent upstream (triggers the push) |
| lead_addr | output | ADDR_W (26) | Leader prefetch line |
| lead_gid | output | GID_W (4) | Leader prefetch group |
| uni_valid | output | 1 | Unicast request upstream |
| uni_addr | output | ADDR_W (26) | Unicast line |
| uni_gid | output | GID_W (4) | Group of the unicast |
| uni_timeout | output | 1 | 1 = caused by timeout, 0 = table full |
| fill_valid | output | 1 | Line written into the cache |
| fill_addr | output | ADDR_W (26) | Filled line |
| pass_valid | output | 1 | Demand forwarded without waiting |
| pass_addr | output | ADDR_W (26) | Forwarded demand line |
| wake_valid | output | 1 | Held demand released |
| wake_addr | output | ADDR_W (26) | Released demand line |

## Verification
The hardest situation to reach is the tie between a line's data and its expiry at exactly the same edge. The stimulus records the cycle at which the follower prefetch is driven, waits exactly `thresh` more cycles and then drives the data, so that both land on one edge. Table exhaustion is the other awkward corner. It is reached by parking one line twice and then 63 further distinct lines, so that exactly one later prefetch must fall back; an extra slot taken by the duplicate would show up as a second fallback.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    typedef enum logic {
        ROLE_FOLLOWER = 1'b0,
        ROLE_LEADER   = 1'b1
    } role_e;
endpackage

// File: rtl/fpw_role_map.sv
module fpw_role_map
    import fpw_pkg::*;
#(
    parameter int GID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [GID_W-1:0] wr_gid,
    input  role_e            wr_role,
    input  logic [GID_W-1:0] rd_gid,
    output role_e            rd_role
);
    localparam int NG = 1 << GID_W;

    logic [NG-1:0] roles_d, roles_q;

    always_comb begin
        roles_d = roles_q;
        if (wr_en) roles_d[wr_gid] = wr_role;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) roles_q <= '0;
        else        roles_q <= roles_d;
    end

    assign rd_role = role_e'(roles_q[rd_gid]);
endmodule

// File: rtl/fpw_match.sv
module fpw_match #(
    parameter int N  = 64,
    parameter int AW = 26
) (
    input  logic [N-1:0]         live,
    input  logic [N-1:0][AW-1:0] addrs,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = live[i] && (addrs[i] == key);
    end
endmodule

// File: rtl/fpw_first.sv
module fpw_first #(
    parameter int N  = 64,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fpw_table.sv
module fpw_table
    import fpw_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int GID_W   = 4,
    parameter int ENTRIES = 64,
    parameter int TMO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  thresh,
    input  logic              map_wr,
    input  logic [GID_W-1:0]  map_gid,
    input  logic              map_leader,
    input  logic              pf_valid,
    input  logic [GID_W-1:0]  pf_gid,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              dmd_valid,
    input  logic [ADDR_W-1:0] dmd_addr,
    input  logic              dat_valid,
    input  logic [ADDR_W-1:0] dat_addr,
    output logic              lead_valid,
    output logic [ADDR_W-1:0] lead_addr,
    output logic [GID_W-1:0]  lead_gid,
    output logic              uni_valid,
    output logic [ADDR_W-1:0] uni_addr,
    output logic [GID_W-1:0]  uni_gid,
    output logic              uni_timeout,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] pass_addr,
    output logic              wake_valid,
    output logic [ADDR_W-1:0] wake_addr
);
    localparam int N  = ENTRIES;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]             v;
        logic [N-1:0][ADDR_W-1:0] addr;
        logic [N-1:0][GID_W-1:0]  gid;
        logic [N-1:0][TMO_W-1:0]  cnt;
        logic [N-1:0]             sent;
        logic [N-1:0]             held;
        logic                     lead_v;
        logic [ADDR_W-1:0]        lead_addr;
        logic [GID_W-1:0]         lead_gid;
        logic                     uni_v;
        logic [ADDR_W-1:0]        uni_addr;
        logic [GID_W-1:0]         uni_gid;
        logic                     uni_tmo;
        logic                     fill_v;
        logic [ADDR_W-1:0]        fill_addr;
        logic                     pass_v;
        logic [ADDR_W-1:0]        pass_addr;
        logic                     wake_v;
        logic [ADDR_W-1:0]        wake_addr;
    } state_t;

    state_t s_d, s_q;

    role_e          pf_role;
    logic [N-1:0]   dat_raw, dat_hit, live, pf_hit, dmd_hit, expire;
    logic           free_found, exp_found;
    logic [IW-1:0]  free_idx, exp_idx;

    fpw_role_map #(.GID_W(GID_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr),
        .wr_gid  (map_gid),
        .wr_role (role_e'(map_leader)),
        .rd_gid  (pf_gid),
        .rd_role (pf_role)
    );

    fpw_match #(.N(N), .AW(ADDR_W)) u_dat_cmp (
        .live (s_q.v), .addrs (s_q.addr), .key (dat_addr), .hit (dat_raw)
    );

    assign dat_hit = dat_raw & {N{dat_valid}};
    assign live    = s_q.v & ~dat_hit;

    fpw_match #(.N(N), .AW(ADDR_W)) u_pf_cmp (
        .live (live), .addrs (s_q.addr), .key (pf_addr), .hit (pf_hit)
    );

    fpw_match #(.N(N), .AW(ADDR_W)) u_dmd_cmp (
        .live (live), .addrs (s_q.addr), .key (dmd_addr), .hit (dmd_hit)
    );

    fpw_first #(.N(N), .IW(IW)) u_free (
        .vec (~s_q.v), .found (free_found), .idx (free_idx)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            expire[i] = live[i] && !s_q.sent[i] && (s_q.cnt[i] >= thresh);
        end
    end

    fpw_first #(.N(N), .IW(IW)) u_exp (
        .vec (expire), .found (exp_found), .idx (exp_idx)
    );

    always_comb begin
        logic fallback;
        s_d      = s_q;
        fallback = 1'b0;
        s_d.lead_v = 1'b0;
        s_d.uni_v  = 1'b0;
        s_d.uni_tmo = 1'b0;
        s_d.fill_v = 1'b0;
        s_d.pass_v = 1'b0;
        s_d.wake_v = 1'b0;

        // age every entry still waiting for the push
        for (int i = 0; i < N; i++) begin
            if (s_q.v[i] && !s_q.sent[i] && (s_q.cnt[i] != '1)) begin
                s_d.cnt[i] = s_q.cnt[i] + 1'b1;
            end
        end

        // incoming line: always filled, retires its entry if any
        if (dat_valid) begin
            s_d.fill_v    = 1'b1;
            s_d.fill_addr = dat_addr;
            if (|(dat_hit & s_q.held)) begin
                s_d.wake_v    = 1'b1;
                s_d.wake_addr = dat_addr;
            end
        end
        s_d.v    = s_d.v & ~dat_hit;
        s_d.held = s_d.held & ~dat_hit;

        // prefetch screening
        if (pf_valid) begin
            if (pf_role == ROLE_LEADER) begin
                s_d.lead_v    = 1'b1;
                s_d.lead_addr = pf_addr;
                s_d.lead_gid  = pf_gid;
            end else if (|pf_hit) begin
                // merged into the waiting entry
            end else if (free_found) begin
                s_d.v[free_idx]    = 1'b1;
                s_d.addr[free_idx] = pf_addr;
                s_d.gid[free_idx]  = pf_gid;
                s_d.cnt[free_idx]  = '0;
                s_d.sent[free_idx] = 1'b0;
                s_d.held[free_idx] = 1'b0;
            end else begin
                fallback     = 1'b1;
                s_d.uni_v    = 1'b1;
                s_d.uni_addr = pf_addr;
                s_d.uni_gid  = pf_gid;
            end
        end

        // timeout fallback; a full-table request has the port this cycle
        if (exp_found && !fallback) begin
            s_d.uni_v          = 1'b1;
            s_d.uni_tmo        = 1'b1;
            s_d.uni_addr       = s_q.addr[exp_idx];
            s_d.uni_gid        = s_q.gid[exp_idx];
            s_d.sent[exp_idx]  = 1'b1;
        end

        // demand screening
        if (dmd_valid) begin
            if (|dmd_hit) begin
                s_d.held = s_d.held | dmd_hit;
            end else begin
                s_d.pass_v    = 1'b1;
                s_d.pass_addr = dmd_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lead_valid  = s_q.lead_v;
    assign lead_addr   = s_q.lead_addr;
    assign lead_gid    = s_q.lead_gid;
    assign uni_valid   = s_q.uni_v;
    assign uni_addr    = s_q.uni_addr;
    assign uni_gid     = s_q.uni_gid;
    assign uni_timeout = s_q.uni_tmo;
    assign fill_valid  = s_q.fill_v;
    assign fill_addr   = s_q.fill_addr;
    assign pass_valid  = s_q.pass_v;
    assign pass_addr   = s_q.pass_addr;
    assign wake_valid  = s_q.wake_v;
    assign wake_addr   = s_q.wake_addr;

    AST_LEAD_FROM_PF: assert property (@(posedge clk) disable iff (!rst_n)
        lead_valid |-> ($past(pf_valid) && $past(pf_addr) == lead_addr)); // R2

    AST_FILL_EVERY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dat_valid) |-> (fill_valid && fill_addr == $past(dat_addr))); // R4

    AST_WAKE_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (fill_valid && fill_addr == wake_addr)); // R5

    AST_FULL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (uni_valid && !uni_timeout) |-> ($past(pf_valid) && $past(pf_addr) == uni_addr)); // R7

    AST_UNIQUE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dat_hit)); // R9

    AST_DATA_BEATS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (uni_valid && uni_timeout) |-> !($past(dat_valid) && $past(dat_addr) == uni_addr)); // R10
endmodule

// File: tb/tb_fpw_table.sv
module tb_fpw_table;
    localparam int AW = 26;
    localparam int GW = 4;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] thresh = '0;
    logic          map_wr = 1'b0, map_leader = 1'b0;
    logic [GW-1:0] map_gid = '0;
    logic          pf_valid = 1'b0;
    logic [GW-1:0] pf_gid = '0;
    logic [AW-1:0] pf_addr = '0;
    logic          dmd_valid = 1'b0;
    logic [AW-1:0] dmd_addr = '0;
    logic          dat_valid = 1'b0;
    logic [AW-1:0] dat_addr = '0;
    logic          lead_valid, uni_valid, uni_timeout, fill_valid, pass_valid, wake_valid;
    logic [AW-1:0] lead_addr, uni_addr, fill_addr, pass_addr, wake_addr;
    logic [GW-1:0] lead_gid, uni_gid;

    fpw_table dut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .map_wr(map_wr), .map_gid(map_gid), .map_leader(map_leader),
        .pf_valid(pf_valid), .pf_gid(pf_gid), .pf_addr(pf_addr),
        .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .dat_valid(dat_valid), .dat_addr(dat_addr),
        .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_gid(lead_gid),
        .uni_valid(uni_valid), .uni_addr(uni_addr), .uni_gid(uni_gid), .uni_timeout(uni_timeout),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .pass_valid(pass_valid), .pass_addr(pass_addr),
        .wake_valid(wake_valid), .wake_addr(wake_addr)
    );

    always #2 clk = ~clk; // 250 MHz

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // channels: 0 lead, 1 unicast, 2 fill, 3 pass, 4 wake
    typedef struct {
        int    cyc;
        int    ch;
        int    addr;
        int    gid;
        bit    tmo;
        string req;
    } exp_t;
    exp_t q[$];

    function automatic void expect_ev(int c, int ch, int addr, int gid, bit tmo, string req);
        exp_t e;
        int pos;
        e.cyc = c; e.ch = ch; e.addr = addr; e.gid = gid; e.tmo = tmo; e.req = req;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc * 8 + q[i].ch > c * 8 + ch) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, e);
    endfunction

    function automatic string ch_req(int ch);
        case (ch)
            0: return "R2";
            1: return "R6";
            2: return "R4";
            3: return "R5";
            default: return "R5";
        endcase
    endfunction

    task automatic check_ch(int ch, bit v, int addr, int gid, bit tmo);
        if (v) begin
            checks++;
            if (q.size() == 0 || q[0].cyc != cyc || q[0].ch != ch) begin
                errors++;
                $display("FAIL %s unexpected output ch=%0d cyc=%0d actual addr=%h expected none",
                         ch_req(ch), ch, cyc, addr);
            end else begin
                if (q[0].addr != addr || ((ch < 2) && q[0].gid != gid) || (ch == 1 && q[0].tmo != tmo)) begin
                    errors++;
                    $display("FAIL %s ch=%0d cyc=%0d actual addr=%h gid=%0d tmo=%0d expected addr=%h gid=%0d tmo=%0d",
                             q[0].req, ch, cyc, addr, gid, tmo, q[0].addr, q[0].gid, q[0].tmo);
                end
                void'(q.pop_front());
            end
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s missing ch=%0d actual none expected addr=%h at cyc=%0d",
                         q[0].req, q[0].ch, q[0].addr, q[0].cyc);
                void'(q.pop_front());
            end
            check_ch(0, lead_valid, int'(lead_addr), int'(lead_gid), 1'b0);
            check_ch(1, uni_valid, int'(uni_addr), int'(uni_gid), uni_timeout);
            check_ch(2, fill_valid, int'(fill_addr), 0, 1'b0);
            check_ch(3, pass_valid, int'(pass_addr), 0, 1'b0);
            check_ch(4, wake_valid, int'(wake_addr), 0, 1'b0);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic drv_map(int g, bit lead);
        map_wr = 1'b1; map_gid = GW'(g); map_leader = lead;
        step();
        map_wr = 1'b0;
    endtask

    task automatic drv_pf(int g, int a);
        pf_valid = 1'b1; pf_gid = GW'(g); pf_addr = AW'(a);
        step();
        pf_valid = 1'b0;
    endtask

    task automatic drv_dmd(int a);
        dmd_valid = 1'b1; dmd_addr = AW'(a);
        step();
        dmd_valid = 1'b0;
    endtask

    task automatic drv_dat(int a);
        dat_valid = 1'b1; dat_addr = AW'(a);
        step();
        dat_valid = 1'b0;
    endtask

    task automatic drv_dat_dmd(int a);
        dat_valid = 1'b1; dat_addr = AW'(a);
        dmd_valid = 1'b1; dmd_addr = AW'(a);
        step();
        dat_valid = 1'b0; dmd_valid = 1'b0;
    endtask

    task automatic reset_check(string name, bit v);
        checks++;
        if (v !== 1'b0) begin
            errors++;
            $display("FAIL R1 %s after reset actual=%b expected=0", name, v);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        idle(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        reset_check("lead_valid", lead_valid);
        reset_check("uni_valid", uni_valid);
        reset_check("fill_valid", fill_valid);
        reset_check("pass_valid", pass_valid);
        reset_check("wake_valid", wake_valid);

        thresh = 16'd300;

        // R2: leader prefetch goes upstream, nothing parked
        drv_map(1, 1'b1);
        expect_ev(cyc + 1, 0, 'h100, 1, 0, "R2");
        drv_pf(1, 'h100);
        expect_ev(cyc + 1, 3, 'h100, 0, 0, "R2");
        drv_dmd('h100);

        // R1/R3: unconfigured group 2 is a follower, prefetch parks silently
        drv_pf(2, 'h200);
        drv_dmd('h200);                              // R5 held, no pass
        expect_ev(cyc + 1, 3, 'h300, 0, 0, "R5");   // unrelated demand passes
        drv_dmd('h300);
        expect_ev(cyc + 1, 2, 'h555, 0, 0, "R8");   // unmatched data fills only
        drv_dat('h555);
        idle(2);                                     // R8: 0x200 still held
        expect_ev(cyc + 1, 2, 'h200, 0, 0, "R4");
        expect_ev(cyc + 1, 4, 'h200, 0, 0, "R5");
        drv_dat('h200);
        expect_ev(cyc + 1, 3, 'h200, 0, 0, "R4");   // entry retired
        drv_dmd('h200);

        // R5: demand in the same cycle as its line's data passes
        drv_pf(2, 'h210);
        expect_ev(cyc + 1, 2, 'h210, 0, 0, "R5");
        expect_ev(cyc + 1, 3, 'h210, 0, 0, "R5");
        drv_dat_dmd('h210);

        // R9 + R7: duplicate merges, then 63 distinct fill the table
        drv_pf(3, 'h1000);
        drv_pf(3, 'h1000);
        for (int i = 1; i < 64; i++) drv_pf(3, 'h1000 + i);
        expect_ev(cyc + 1, 1, 'h1040, 3, 0, "R7");
        drv_pf(3, 'h1040);
        expect_ev(cyc + 1, 1, 'h1041, 3, 0, "R9");
        drv_pf(3, 'h1041);
        for (int i = 0; i < 64; i++) begin
            expect_ev(cyc + 1, 2, 'h1000 + i, 0, 0, "R4");
            drv_dat('h1000 + i);
        end
        expect_ev(cyc + 1, 3, 'h1000, 0, 0, "R4");
        drv_dmd('h1000);

        // R6: timeout after thresh+1 cycles from the sampling edge
        thresh = 16'd10;
        idle(1);
        c = cyc;
        expect_ev(c + 12, 1, 'h700, 6, 1, "R6");
        drv_pf(6, 'h700);
        idle(12);
        drv_dmd('h700);                              // still held after timeout
        idle(30);                                    // no second unicast
        expect_ev(cyc + 1, 2, 'h700, 0, 0, "R6");
        expect_ev(cyc + 1, 4, 'h700, 0, 0, "R6");
        drv_dat('h700);

        // R10: data on the expiry edge suppresses the timeout
        c = cyc;
        drv_pf(6, 'h800);
        idle(10);
        if (cyc != c + 11) begin
            checks++;
            errors++;
            $display("FAIL R10 bench timing actual cyc=%0d expected=%0d", cyc, c + 11);
        end
        expect_ev(cyc + 1, 2, 'h800, 0, 0, "R10");
        drv_dat('h800);
        idle(25);

        // R11: role changes take effect on later prefetches
        thresh = 16'd300;
        drv_map(1, 1'b0);
        drv_pf(1, 'h900);                            // now follower: parked
        expect_ev(cyc + 1, 2, 'h900, 0, 0, "R11");
        drv_dat('h900);
        drv_map(2, 1'b1);
        expect_ev(cyc + 1, 0, 'h901, 2, 0, "R11");
        drv_pf(2, 'h901);

        idle(5);
        done = 1'b1;
        while (q.size() > 0) begin
            checks++;
            errors++;
            $display("FAIL %s never seen ch=%0d actual none expected addr=%h",
                     q[0].req, q[0].ch, q[0].addr);
            void'(q.pop_front());
        end
        summary();
        $finish;
    end
endmodule